// File: doc/BRIEF.md
# Registered 32-bit Integer ALU with Condition Flags

This block performs one integer operation per strobe on two operands: add, subtract, compare, AND, OR, XOR, bitwise inversion or two's-complement negation. The outcome is captured in an output register on the clock edge where `valid_i` is high. A one-cycle write-back indication tells the surrounding datapath whether the captured result should be committed to its destination.

Four condition flags (sign, zero, carry, overflow) are kept in a state register. Each operation has its own update rule. Compare updates the flags the way subtract does but never requests a write-back. Inversion leaves every flag alone. Negating the most negative number is reported as an overflow and produces no write-back.

Operands are taken as given. Register fetch, decode, addressing, multiply and divide belong to the surrounding logic.

Top module: `alu_flags_core`

## Requirements
- R1: While `rst_ni` is low, `result_o`, `wr_en_o`, `sf_o`, `zf_o`, `cf_o` and `of_o` are all 0.
- R2: `op_i` = 0 (add) captures `a_i + b_i` modulo 2^32. CF is the unsigned carry out of bit 31. OF is set when the signed sum does not fit in 32 bits. SF is bit 31 of the result and ZF is (result == 0).
- R3: `op_i` = 1 (subtract) captures `a_i - b_i`. CF is set when an unsigned borrow occurs (`a_i < b_i`). OF is set when the signed difference does not fit in 32 bits. SF and ZF are taken from the result.
- R4: `op_i` = 2 (compare) updates all four flags exactly as subtract would. `wr_en_o` stays 0 and `result_o` keeps its previous value.
- R5: `op_i` = 3, 4 and 5 capture `a_i & b_i`, `a_i | b_i` and `a_i ^ b_i` respectively. SF is bit 31 of the result, ZF is (result == 0), and CF and OF are cleared.
- R6: `op_i` = 6 captures `~a_i` and leaves all four flags unchanged.
- R7: `op_i` = 7 (negate) with `a_i` other than 0x80000000 captures `-a_i`, clears OF, sets CF exactly when `a_i` is nonzero, and takes SF and ZF from the result.
- R8: Negate of 0x80000000 sets SF=1, ZF=0 and OF=1 and leaves CF unchanged. `wr_en_o` stays 0 and `result_o` keeps its previous value.
- R9: A cycle with `valid_i` low changes no output except that `wr_en_o` is 0.
- R10: Outputs change on the rising edge where `valid_i` is sampled high. `wr_en_o` is 1 for exactly the following cycle when the operation writes back (every operation except compare and negate of 0x80000000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 3 | Operation select (encoding as in R2–R8) |
| a_i | input | 32 | First operand (destination side) |
| b_i | input | 32 | Second operand |
| result_o | output | 32 | Registered result |
| wr_en_o | output | 1 | Result should be written back this cycle |
| sf_o | output | 1 | Sign flag |
| zf_o | output | 1 | Zero flag |
| cf_o | output | 1 | Carry / borrow flag |
| of_o | output | 1 | Signed overflow flag |

## Verification
Add is driven with operand pairs chosen to set signed overflow only, unsigned carry only, and both at once. These pairs separate the carry logic from the overflow logic. Subtract and compare use 0−1, minimum minus maximum, and pairs where the operands are equal or where the signed and unsigned orderings disagree. These confirm that borrow and overflow are independent and that compare suppresses the write-back. Logic operations are given patterns whose results are zero or have bit 31 set, and they are issued after flag-setting operations so that a carry or overflow left standing would show. Negate of zero, one and the minimum value, together with inversion issued after a known flag state, separate the operations that update flags from those that hold them. A pseudo-random sweep over all eight encodings is compared against an independent model.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_CMP = 3'd2,
    OP_AND = 3'd3,
    OP_OR  = 3'd4,
    OP_XOR = 3'd5,
    OP_NOT = 3'd6,
    OP_NEG = 3'd7
  } alu_op_e;

  typedef struct packed {
    logic s;
    logic z;
    logic c;
    logic o;
  } alu_flags_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] res_o,
  output logic             cf_o,
  output logic             of_o
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   sum;

  // subtract as a + ~b + 1; borrow is the inverted carry
  assign b_eff = sub_i ? ~b_i : b_i;
  assign sum   = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_i};
  assign res_o = sum[WIDTH-1:0];
  assign cf_o  = sum[WIDTH] ^ sub_i;
  assign of_o  = (a_i[MSB] == b_eff[MSB]) && (sum[MSB] != a_i[MSB]);

endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_op_e          op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      default: res_o = ~a_i;
    endcase
  end

endmodule

// File: rtl/alu_neg.sv
module alu_neg #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  output logic [WIDTH-1:0] res_o,
  output logic             min_o,
  output logic             cf_o
);
  localparam logic [WIDTH-1:0] MIN_VAL = {1'b1, {(WIDTH-1){1'b0}}};

  assign res_o = ~a_i + {{(WIDTH-1){1'b0}}, 1'b1};
  assign min_o = (a_i == MIN_VAL);
  assign cf_o  = |a_i;

endmodule

// File: rtl/alu_flags_core.sv
module alu_flags_core
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [2:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] result_o,
  output logic             wr_en_o,
  output logic             sf_o,
  output logic             zf_o,
  output logic             cf_o,
  output logic             of_o
);
  localparam int MSB = WIDTH - 1;

  alu_op_e op;
  assign op = alu_op_e'(op_i);

  logic [WIDTH-1:0] as_res, lg_res, ng_res;
  logic             as_cf, as_of, ng_min, ng_cf;

  alu_addsub #(.WIDTH(WIDTH)) i_addsub (
    .a_i   (a_i),
    .b_i   (b_i),
    .sub_i (op != OP_ADD),
    .res_o (as_res),
    .cf_o  (as_cf),
    .of_o  (as_of)
  );

  alu_logic #(.WIDTH(WIDTH)) i_logic (
    .op_i  (op),
    .a_i   (a_i),
    .b_i   (b_i),
    .res_o (lg_res)
  );

  alu_neg #(.WIDTH(WIDTH)) i_neg (
    .a_i   (a_i),
    .res_o (ng_res),
    .min_o (ng_min),
    .cf_o  (ng_cf)
  );

  logic [WIDTH-1:0] res_q, res_d;
  logic             we_q, we_d;
  alu_flags_t       flg_q, flg_d;

  always_comb begin
    res_d = res_q;
    we_d  = 1'b0;
    flg_d = flg_q;
    if (valid_i) begin
      unique case (op)
        OP_ADD, OP_SUB, OP_CMP: begin
          flg_d = '{s: as_res[MSB], z: (as_res == '0), c: as_cf, o: as_of};
          if (op != OP_CMP) begin
            res_d = as_res;
            we_d  = 1'b1;
          end
        end
        OP_AND, OP_OR, OP_XOR: begin
          flg_d = '{s: lg_res[MSB], z: (lg_res == '0), c: 1'b0, o: 1'b0};
          res_d = lg_res;
          we_d  = 1'b1;
        end
        OP_NOT: begin
          res_d = lg_res;
          we_d  = 1'b1;
        end
        default: begin
          if (ng_min) begin
            // overflow: operand kept, carry untouched
            flg_d.s = 1'b1;
            flg_d.z = 1'b0;
            flg_d.o = 1'b1;
          end else begin
            flg_d = '{s: ng_res[MSB], z: (ng_res == '0), c: ng_cf, o: 1'b0};
            res_d = ng_res;
            we_d  = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      we_q  <= 1'b0;
      flg_q <= '0;
    end else begin
      res_q <= res_d;
      we_q  <= we_d;
      flg_q <= flg_d;
    end
  end

  assign result_o = res_q;
  assign wr_en_o  = we_q;
  assign sf_o     = flg_q.s;
  assign zf_o     = flg_q.z;
  assign cf_o     = flg_q.c;
  assign of_o     = flg_q.o;

  AST_CMP_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd2) |=> (!wr_en_o && $stable(result_o))); // R4

  AST_LOGIC_CLEARS_CO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == 3'd3 || op_i == 3'd4 || op_i == 3'd5)) |=> (!cf_o && !of_o)); // R5

  AST_NOT_KEEPS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd6) |=> $stable({sf_o, zf_o, cf_o, of_o})); // R6

  AST_NEG_MIN_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd7 && a_i == {1'b1, {(WIDTH-1){1'b0}}})
    |=> (sf_o && !zf_o && of_o && !wr_en_o && $stable(cf_o))); // R8

  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!wr_en_o && $stable(result_o) && $stable({sf_o, zf_o, cf_o, of_o}))); // R9

  AST_ZERO_MATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && $past(op_i) != 3'd6) |-> (zf_o == (result_o == '0))); // R2

endmodule

// File: tb/test_alu_flags_core.sv
module test_alu_flags_core;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = 3'd0;
  logic [31:0] a_i = '0, b_i = '0;
  logic [31:0] result_o;
  logic        wr_en_o, sf_o, zf_o, cf_o, of_o;

  alu_flags_core #(.WIDTH(32)) i_alu_flags_core (
    .clk_i, .rst_ni, .valid_i, .op_i, .a_i, .b_i,
    .result_o, .wr_en_o, .sf_o, .zf_o, .cf_o, .of_o
  );

  always #4 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // independent model state
  logic [31:0] m_res = '0;
  logic        m_we = 0, m_s = 0, m_z = 0, m_c = 0, m_o = 0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(string tag);
    chk(tag, "result", result_o, m_res);
    chk(tag, "wr_en", 32'(wr_en_o), 32'(m_we));
    chk(tag, "flags SZCO", {28'd0, sf_o, zf_o, cf_o, of_o}, {28'd0, m_s, m_z, m_c, m_o});
  endtask

  task automatic model(logic [2:0] op, logic [31:0] a, logic [31:0] b);
    logic [31:0] r;
    longint sa, sb;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    m_we = 0;
    case (op)
      3'd0: begin
        r = a + b;
        m_res = r; m_we = 1;
        m_s = r[31]; m_z = (r == 0);
        m_c = ({32'd0, a} + {32'd0, b}) > 64'hffff_ffff;
        m_o = (sa + sb) != longint'($signed(r));
      end
      3'd1, 3'd2: begin
        r = a - b;
        if (op == 3'd1) begin m_res = r; m_we = 1; end
        m_s = r[31]; m_z = (r == 0);
        m_c = (a < b);
        m_o = (sa - sb) != longint'($signed(r));
      end
      3'd3, 3'd4, 3'd5: begin
        r = (op == 3'd3) ? (a & b) : (op == 3'd4) ? (a | b) : (a ^ b);
        m_res = r; m_we = 1;
        m_s = r[31]; m_z = (r == 0); m_c = 0; m_o = 0;
      end
      3'd6: begin
        m_res = ~a; m_we = 1;
      end
      default: begin
        if (a == 32'h8000_0000) begin
          m_s = 1; m_z = 0; m_o = 1;
        end else begin
          r = 32'(-sa);
          m_res = r; m_we = 1;
          m_s = r[31]; m_z = (r == 0); m_o = 0; m_c = (a != 0);
        end
      end
    endcase
  endtask

  // one strobe, then sample one cycle later away from the edge
  task automatic run_op(string tag, logic [2:0] op, logic [31:0] a, logic [31:0] b);
    @(negedge clk_i);
    valid_i = 1; op_i = op; a_i = a; b_i = b;
    model(op, a, b);
    @(negedge clk_i);
    valid_i = 0;
    chk_all(tag);
    m_we = 0;
  endtask

  task automatic exp_val(string tag, logic [31:0] r, logic [3:0] szco);
    chk(tag, "stated result", result_o, r);
    chk(tag, "stated SZCO", {28'd0, sf_o, zf_o, cf_o, of_o}, {28'd0, szco});
  endtask

  task automatic t_reset;
    #1;
    chk("R1", "result", result_o, 0);
    chk("R1", "wr_en+flags", {27'd0, wr_en_o, sf_o, zf_o, cf_o, of_o}, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
  endtask

  task automatic t_add;
    run_op("R2", 3'd0, 32'h7fff_ffff, 32'h1);
    exp_val("R2", 32'h8000_0000, 4'b1001);
    run_op("R2", 3'd0, 32'hffff_ffff, 32'h1);
    exp_val("R2", 32'h0, 4'b0110);
    run_op("R2", 3'd0, 32'h8000_0000, 32'h8000_0000);
    exp_val("R2", 32'h0, 4'b0111);
    run_op("R2", 3'd0, 32'h10, 32'h1);
    exp_val("R2", 32'h11, 4'b0000);
  endtask

  task automatic t_sub;
    run_op("R3", 3'd1, 32'h0, 32'h1);
    exp_val("R3", 32'hffff_ffff, 4'b1010);
    run_op("R3", 3'd1, 32'h8000_0000, 32'h7fff_ffff);
    exp_val("R3", 32'h1, 4'b0001);
    run_op("R3", 3'd1, 32'h0, 32'h8000_0000);
    exp_val("R3", 32'h8000_0000, 4'b1011);
    run_op("R3", 3'd1, 32'd10, 32'd10);
    exp_val("R3", 32'h0, 4'b0100);
  endtask

  task automatic t_cmp;
    run_op("R4", 3'd0, 32'h1234, 32'h1);
    run_op("R4", 3'd2, 32'h7fff_ffff, 32'h8000_0000);
    exp_val("R4", 32'h1235, 4'b1011);
    run_op("R4", 3'd2, 32'hffff_ffff, 32'h1);
    run_op("R4", 3'd2, 32'h1, 32'hffff_ffff);
    run_op("R4", 3'd2, 32'h0a0b_0c0d, 32'h0a0b_0c0d);
  endtask

  task automatic t_logic;
    run_op("R5", 3'd0, 32'h8000_0000, 32'h8000_0000); // leave C and O set
    run_op("R5", 3'd3, 32'h0a0b_0c0d, 32'h0000_00ff);
    exp_val("R5", 32'h0000_000d, 4'b0000);
    run_op("R5", 3'd0, 32'h7fff_ffff, 32'h1);
    run_op("R5", 3'd4, 32'h0a0b_0c0d, 32'ha0b0_c0d0);
    exp_val("R5", 32'haabb_ccdd, 4'b1000);
    run_op("R5", 3'd5, 32'h5555_aaaa, 32'h5555_aaaa);
    exp_val("R5", 32'h0, 4'b0100);
  endtask

  task automatic t_not;
    run_op("R6", 3'd0, 32'h8000_0000, 32'h8000_0000);
    run_op("R6", 3'd6, 32'h0f0f_00ff, 32'h0);
    exp_val("R6", 32'hf0f0_ff00, 4'b0111);
    run_op("R6", 3'd1, 32'h0, 32'h1);
    run_op("R6", 3'd6, 32'hffff_ffff, 32'h0);
    exp_val("R6", 32'h0, 4'b1010);
  endtask

  task automatic t_neg;
    run_op("R7", 3'd7, 32'h1, 32'h0);
    exp_val("R7", 32'hffff_ffff, 4'b1010);
    run_op("R7", 3'd7, 32'h0, 32'h0);
    exp_val("R7", 32'h0, 4'b0100);
    run_op("R7", 3'd7, 32'hffff_fffd, 32'h0);
    exp_val("R7", 32'h3, 4'b0010);
  endtask

  task automatic t_neg_min;
    run_op("R8", 3'd3, 32'h0, 32'h0);       // carry clear
    run_op("R8", 3'd7, 32'h8000_0000, 32'h0);
    exp_val("R8", 32'h0, 4'b1001);
    run_op("R8", 3'd0, 32'hffff_ffff, 32'h2); // carry set, result 1
    run_op("R8", 3'd7, 32'h8000_0000, 32'h0);
    exp_val("R8", 32'h1, 4'b1011);
  endtask

  task automatic t_idle;
    run_op("R9", 3'd4, 32'h00c0_ffee, 32'h0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      op_i = 3'(i); a_i = 32'hdead_0000 + 32'(i); b_i = 32'h1;
      @(negedge clk_i);
      chk_all("R9");
    end
  endtask

  task automatic t_sweep;
    logic [31:0] x = 32'h1357_9bdf;
    for (int i = 0; i < 64; i++) begin
      logic [31:0] a, b;
      x = x * 32'd1664525 + 32'd1013904223; a = x;
      x = x * 32'd1664525 + 32'd1013904223; b = (i % 5 == 0) ? a : x;
      run_op("R10", 3'(i), a, b);
      @(negedge clk_i);
      chk("R10", "wr_en one cycle", 32'(wr_en_o), 0);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_cmp();
    t_logic();
    t_not();
    t_neg();
    t_neg_min();
    t_idle();
    t_sweep();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule